// File: doc/BRIEF.md
# Load/Store Address Generator with Base Update

This block drives the address side of one memory transfer instruction on a short three-stage core. A start strobe captures a base value, an offset and four control flags. In the first cycle one adder/subtractor forms base plus or minus offset. The memory address register is then loaded with that sum for pre-indexed access, or with the unchanged base for post-indexed access. In the second cycle the transfer strobe is raised and the memory bus moves data. In that same cycle the same adder, still fed from the held operands, gives the updated base value for the register bank. Its write enable is raised when base update is requested or when post-indexing applies.

The offset comes either from a second register value or from an immediate field, which is zero-extended to the datapath width. The controller is a three-state machine. `XS_IDLE` waits for `start_i`. The idle-to-address transition happens on a start, and the operands are captured on that edge. `XS_ADDR` is the address-forming cycle, and it always moves to `XS_XFER`. `XS_XFER` is the transfer and base-update cycle, and it always returns to `XS_IDLE`. A start seen outside `XS_IDLE` has no effect.

Top module: `xfer_addr_unit`

## Requirements
- R1: After reset `busy_o`, `xfer_o` and `wb_en_o` are 0 and `mem_addr_o` is 0.
- R2: A `start_i` sampled high while idle makes `busy_o` high for exactly the next two cycles (address cycle, then transfer cycle), after which it returns to 0.
- R3: `xfer_o` is high for exactly one cycle, the second cycle after the start edge, and `mem_addr_o` takes its new value at the same edge at which `xfer_o` rises.
- R4: With `use_imm_i`=1 the offset is `off_imm_i` zero-extended to W bits; with `use_imm_i`=0 it is `off_reg_i`.
- R5: With `add_dir_i`=1 the sum is base+offset, with `add_dir_i`=0 it is base-offset, both modulo 2^W.
- R6: With `pre_idx_i`=1 the issued `mem_addr_o` is the sum; with `pre_idx_i`=0 it is the unmodified base.
- R7: During the transfer cycle `wb_val_o` equals the sum, and `wb_en_o` is high only in that cycle and only when `wb_req_i`=1 or `pre_idx_i`=0.
- R8: A `start_i` while `busy_o` is high is ignored: the cycle count, the address and the base-update value of the running operation are unchanged.
- R9: Operand and flag inputs are sampled only at the start edge; later changes do not affect the running operation.
- R10: `mem_addr_o` holds its value after the transfer cycle until the next address cycle ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation when idle |
| base_i | input | W | Base register value |
| off_reg_i | input | W | Register offset value |
| off_imm_i | input | IMM_W | Immediate offset field |
| use_imm_i | input | 1 | 1 selects immediate offset |
| add_dir_i | input | 1 | 1 add offset, 0 subtract |
| pre_idx_i | input | 1 | 1 pre-indexed, 0 post-indexed |
| wb_req_i | input | 1 | Base update requested |
| busy_o | output | 1 | Operation in progress |
| xfer_o | output | 1 | Memory transfer cycle strobe |
| mem_addr_o | output | W | Memory address register |
| wb_val_o | output | W | Updated base value |
| wb_en_o | output | 1 | Base write enable |

## Verification
A state machine stuck or skipping a state shows at the ports within one or two cycles. `busy_o` would stay high, or drop after one cycle, and `xfer_o` would appear at the wrong cycle or not at all. Held operands that are wrongly captured or overwritten show in the transfer cycle as a wrong `mem_addr_o` or `wb_val_o`. This is why the operand inputs are changed and start is re-pulsed during every busy window. A wrong pre/post or direction decode shows in the same cycle in all four flag combinations, which the vector table covers with both register and immediate offsets and with wrap-around.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
    typedef enum logic [1:0] {
        XS_IDLE = 2'd0,
        XS_ADDR = 2'd1,
        XS_XFER = 2'd2
    } xfer_state_t;
endpackage

// File: rtl/xfer_seq_fsm.sv
module xfer_seq_fsm
    import xfer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic capture_o,
    output logic addr_load_o,
    output logic xfer_o,
    output logic busy_o
);
    xfer_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= XS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XS_IDLE: if (start_i) state_d = XS_ADDR;
            XS_ADDR: state_d = XS_XFER;
            XS_XFER: state_d = XS_IDLE;
            default: state_d = XS_IDLE;
        endcase
    end

    always_comb begin
        capture_o   = 1'b0;
        addr_load_o = 1'b0;
        xfer_o      = 1'b0;
        busy_o      = 1'b0;
        unique case (state_q)
            XS_IDLE: capture_o = start_i;
            XS_ADDR: begin
                addr_load_o = 1'b1;
                busy_o      = 1'b1;
            end
            XS_XFER: begin
                xfer_o = 1'b1;
                busy_o = 1'b1;
            end
            default: ;
        endcase
    end

    // R2: an address cycle is always followed by the transfer cycle
    assert_addr_then_xfer_R2: assert property (@(posedge clk) disable iff (!rst_n)
        addr_load_o |=> xfer_o);
    // R3: transfer strobe lasts one cycle only
    assert_xfer_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_o |=> !xfer_o && !busy_o);
    // R8: a start while busy does not begin a capture
    assert_no_capture_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !capture_o);
endmodule

// File: rtl/xfer_hold_regs.sv
module xfer_hold_regs #(
    parameter int W     = 32,
    parameter int IMM_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture_i,
    input  logic [W-1:0]     base_i,
    input  logic [W-1:0]     off_reg_i,
    input  logic [IMM_W-1:0] off_imm_i,
    input  logic             use_imm_i,
    input  logic             add_dir_i,
    input  logic             pre_idx_i,
    input  logic             wb_req_i,
    output logic [W-1:0]     base_q,
    output logic [W-1:0]     off_q,
    output logic             add_q,
    output logic             pre_q,
    output logic             wb_q
);
    localparam int IMM_PAD = W - IMM_W;

    logic [W-1:0] imm_ext;
    logic [W-1:0] off_sel;

    generate
        if (IMM_PAD > 0) begin : g_pad
            assign imm_ext = {{IMM_PAD{1'b0}}, off_imm_i};
        end else begin : g_nopad
            assign imm_ext = off_imm_i[W-1:0];
        end
    endgenerate

    assign off_sel = use_imm_i ? imm_ext : off_reg_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            off_q  <= '0;
            add_q  <= 1'b0;
            pre_q  <= 1'b0;
            wb_q   <= 1'b0;
        end else if (capture_i) begin
            base_q <= base_i;
            off_q  <= off_sel;
            add_q  <= add_dir_i;
            pre_q  <= pre_idx_i;
            wb_q   <= wb_req_i;
        end
    end
endmodule

// File: rtl/xfer_addsub.sv
module xfer_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         add_i,
    output logic [W-1:0] sum_o
);
    always_comb begin
        if (add_i) sum_o = a_i + b_i;
        else       sum_o = a_i - b_i;
    end
endmodule

// File: rtl/xfer_addr_unit.sv
module xfer_addr_unit #(
    parameter int W     = 32,
    parameter int IMM_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [W-1:0]     base_i,
    input  logic [W-1:0]     off_reg_i,
    input  logic [IMM_W-1:0] off_imm_i,
    input  logic             use_imm_i,
    input  logic             add_dir_i,
    input  logic             pre_idx_i,
    input  logic             wb_req_i,
    output logic             busy_o,
    output logic             xfer_o,
    output logic [W-1:0]     mem_addr_o,
    output logic [W-1:0]     wb_val_o,
    output logic             wb_en_o
);
    logic         capture, addr_load;
    logic [W-1:0] base_q, off_q, sum;
    logic         add_q, pre_q, wb_q;
    logic [W-1:0] mem_addr_q;

    xfer_seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .capture_o   (capture),
        .addr_load_o (addr_load),
        .xfer_o      (xfer_o),
        .busy_o      (busy_o)
    );

    xfer_hold_regs #(.W(W), .IMM_W(IMM_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (capture),
        .base_i    (base_i),
        .off_reg_i (off_reg_i),
        .off_imm_i (off_imm_i),
        .use_imm_i (use_imm_i),
        .add_dir_i (add_dir_i),
        .pre_idx_i (pre_idx_i),
        .wb_req_i  (wb_req_i),
        .base_q    (base_q),
        .off_q     (off_q),
        .add_q     (add_q),
        .pre_q     (pre_q),
        .wb_q      (wb_q)
    );

    // one adder serves both the address cycle and the base-update cycle
    xfer_addsub #(.W(W)) u_add (
        .a_i   (base_q),
        .b_i   (off_q),
        .add_i (add_q),
        .sum_o (sum)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         mem_addr_q <= '0;
        else if (addr_load) mem_addr_q <= pre_q ? sum : base_q;
    end

    assign mem_addr_o = mem_addr_q;
    assign wb_val_o   = xfer_o ? sum : '0;
    assign wb_en_o    = xfer_o & (wb_q | ~pre_q);

    // R7: write enable only inside the transfer cycle
    assert_wb_in_xfer_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en_o |-> xfer_o);
    // R6: pre-indexed issue address equals the updated base
    assert_pre_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_o && pre_q) |-> (mem_addr_o == wb_val_o));
    // R6: post-indexed issue address is the held base
    assert_post_base_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_o && !pre_q) |-> (mem_addr_o == base_q));
    // R10: address register is not reloaded after the transfer cycle
    assert_addr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_o |=> $stable(mem_addr_o));
endmodule

// File: tb/sim_xfer_addr_unit.sv
module sim_xfer_addr_unit;
    localparam int  PERIOD = 10;
    localparam int  W      = 32;
    localparam int  IMM_W  = 12;
    localparam int  NV     = 8;

    typedef struct packed {
        logic [31:0] base;
        logic [31:0] rego;
        logic [11:0] imm;
        logic        use_imm;
        logic        add;
        logic        pre;
        logic        wb;
        logic [31:0] exp_addr;
        logic [31:0] exp_wbv;
        logic        exp_en;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{32'h0000_1000, 32'h0000_0020, 12'h000, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0000_1020, 32'h0000_1020, 1'b0},
        '{32'h0000_1000, 32'h0000_0020, 12'h000, 1'b0, 1'b0, 1'b1, 1'b1, 32'h0000_0FE0, 32'h0000_0FE0, 1'b1},
        '{32'h0000_2000, 32'h0000_0000, 12'hFFF, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0000_2000, 32'h0000_2FFF, 1'b1},
        '{32'h0000_2000, 32'h0000_0000, 12'h004, 1'b1, 1'b0, 1'b0, 1'b1, 32'h0000_2000, 32'h0000_1FFC, 1'b1},
        '{32'h0000_0004, 32'h0000_0008, 12'h000, 1'b0, 1'b0, 1'b1, 1'b0, 32'hFFFF_FFFC, 32'hFFFF_FFFC, 1'b0},
        '{32'hFFFF_FFF0, 32'h0000_0020, 12'h000, 1'b0, 1'b1, 1'b1, 1'b1, 32'h0000_0010, 32'h0000_0010, 1'b1},
        '{32'h8000_0000, 32'h0000_DEAD, 12'h800, 1'b1, 1'b1, 1'b1, 1'b0, 32'h8000_0800, 32'h8000_0800, 1'b0},
        '{32'h0000_0040, 32'h0000_0100, 12'h007, 1'b0, 1'b1, 1'b0, 1'b1, 32'h0000_0040, 32'h0000_0140, 1'b1}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [W-1:0]     base_i = '0;
    logic [W-1:0]     off_reg_i = '0;
    logic [IMM_W-1:0] off_imm_i = '0;
    logic             use_imm_i = 1'b0;
    logic             add_dir_i = 1'b0;
    logic             pre_idx_i = 1'b0;
    logic             wb_req_i = 1'b0;
    logic             busy_o, xfer_o, wb_en_o;
    logic [W-1:0]     mem_addr_o, wb_val_o;

    int total = 0;
    int bad   = 0;

    always #(PERIOD/2) clk = ~clk;

    xfer_addr_unit #(.W(W), .IMM_W(IMM_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .base_i(base_i), .off_reg_i(off_reg_i), .off_imm_i(off_imm_i),
        .use_imm_i(use_imm_i), .add_dir_i(add_dir_i), .pre_idx_i(pre_idx_i),
        .wb_req_i(wb_req_i), .busy_o(busy_o), .xfer_o(xfer_o),
        .mem_addr_o(mem_addr_o), .wb_val_o(wb_val_o), .wb_en_o(wb_en_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        base_i    = v.base;
        off_reg_i = v.rego;
        off_imm_i = v.imm;
        use_imm_i = v.use_imm;
        add_dir_i = v.add;
        pre_idx_i = v.pre;
        wb_req_i  = v.wb;
    endtask

    task automatic scramble();
        base_i    = ~base_i;
        off_reg_i = off_reg_i + 32'h1234;
        off_imm_i = ~off_imm_i;
        use_imm_i = ~use_imm_i;
        add_dir_i = ~add_dir_i;
        pre_idx_i = ~pre_idx_i;
        wb_req_i  = ~wb_req_i;
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        @(negedge clk);
        drive(v);
        start_i = 1'b1;
        @(negedge clk);                 // address cycle
        chk($sformatf("R2 busy addr v%0d", idx), {31'b0, busy_o}, 32'd1);
        chk($sformatf("R3 no xfer addr v%0d", idx), {31'b0, xfer_o}, 32'd0);
        scramble();                     // R9: later input changes ignored
        start_i = 1'b1;                 // R8: start while busy ignored
        @(negedge clk);                 // transfer cycle
        chk($sformatf("R3 xfer v%0d", idx), {31'b0, xfer_o}, 32'd1);
        chk($sformatf("R6 addr v%0d", idx), mem_addr_o, v.exp_addr);
        chk($sformatf("R7 wbval v%0d", idx), wb_val_o, v.exp_wbv);
        chk($sformatf("R7 wben v%0d", idx), {31'b0, wb_en_o}, {31'b0, v.exp_en});
        chk($sformatf("R2 busy xfer v%0d", idx), {31'b0, busy_o}, 32'd1);
        @(negedge clk);                 // back to idle
        start_i = 1'b0;
        chk($sformatf("R2 idle v%0d", idx), {31'b0, busy_o}, 32'd0);
        chk($sformatf("R8 no restart v%0d", idx), {31'b0, xfer_o | wb_en_o}, 32'd0);
        chk($sformatf("R10 hold v%0d", idx), mem_addr_o, v.exp_addr);
    endtask

    initial begin
        #(PERIOD * 200000);
        bad++;
        total++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1 busy", {31'b0, busy_o}, 32'd0);
        chk("R1 xfer", {31'b0, xfer_o}, 32'd0);
        chk("R1 wben", {31'b0, wb_en_o}, 32'd0);
        chk("R1 addr", mem_addr_o, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after release", {31'b0, busy_o}, 32'd0);

        // table: R4 offset select, R5 direction, R6 pre/post, R7 update
        for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

        // R10: address holds through idle cycles
        repeat (4) @(negedge clk);
        chk("R10 hold idle", mem_addr_o, VECS[NV-1].exp_addr);

        // R4: immediate at full width, register offset ignored
        begin
            vec_t v;
            v = '{32'h0000_0000, 32'hFFFF_FFFF, 12'hABC, 1'b1, 1'b1, 1'b1, 1'b1,
                  32'h0000_0ABC, 32'h0000_0ABC, 1'b1};
            run_vec(v, 100);
        end

        // R2/R3: back-to-back starts held high continuously
        @(negedge clk);
        drive(VECS[0]);
        start_i = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R3 b2b first xfer", {31'b0, xfer_o}, 32'd1);
        chk("R6 b2b addr", mem_addr_o, VECS[0].exp_addr);
        drive(VECS[1]);
        @(negedge clk);
        chk("R2 b2b idle gap", {31'b0, busy_o}, 32'd0);
        @(negedge clk);
        start_i = 1'b0;
        chk("R2 b2b restart busy", {31'b0, busy_o}, 32'd1);
        chk("R10 b2b addr held in addr cycle", mem_addr_o, VECS[0].exp_addr);
        @(negedge clk);
        chk("R6 b2b second addr", mem_addr_o, VECS[1].exp_addr);
        chk("R7 b2b second wben", {31'b0, wb_en_o}, 32'd1);
        @(negedge clk);

        // R1: reset in mid operation returns to idle values
        drive(VECS[5]);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        rst_n = 1'b0;
        #1;
        chk("R1 mid reset busy", {31'b0, busy_o}, 32'd0);
        chk("R1 mid reset addr", mem_addr_o, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule